// File: doc/BRIEF.md
# Center-Aligned PWM Timer Core

This block is an up/down counter for symmetric (center-aligned) pulse-width modulation. From reset it counts up from zero. On a count step taken at the active period value it moves one further, to period+1, and the next step turns it around to count down. When it reaches zero it turns around again and counts up. The counter moves only on cycles where both the run enable and the count-rate strobe are high, so a prescaler outside the block sets the count rate.

Two period indications come out. The external match line pulses whenever the counter steps away from a value equal to the period. Because the counter passes through the period value on the way up and again on the way down, this line pulses twice per turnaround. The internal period event fires only for the up-count match, so it fires once per PWM cycle. That event also copies the shadow period and compare values into the active registers. A zero-match pulse marks the bottom of each cycle. One compare channel drives a PWM output that is high while the count is at or above the active compare value, which gives a pulse centred on the peak.

Top module: `capwm_timer`

## Requirements
- R1: After reset the count is 0 and the direction is up (`count_up`=1). The active and shadow period and compare values hold the parameters RST_PERIOD (default 8) and RST_COMPARE (default 4).
- R2: The counter and the direction change only on a rising clock edge where `en` and `step` are both 1. Otherwise both hold their values, and no match pulse is produced.
- R3: While counting up, each step adds 1. A step taken at a count above the active period (that is, at period+1) sets the count to period and the direction to down. For a period of 0x200 the counts run 0x1FE, 0x1FF, 0x200, 0x201, 0x200, 0x1FF, 0x1FE.
- R4: While counting down, each step subtracts 1. A step taken at count 0 sets the count to 1 and the direction to up.
- R5: `pm_ext` is 1 for exactly the cycles in which the counter steps while the count equals the active period, in either direction. It therefore pulses twice per turnaround.
- R6: `pm_int` is 1 for exactly the cycles in which the counter steps up while the count equals the active period. This happens once per PWM cycle.
- R7: `zero_match` is 1 for exactly the cycles in which the counter steps while the count is 0.
- R8: `shadow_wr`=1 loads `period_in` and `compare_in` into the shadow registers at the clock edge. The shadow values move into the active registers at the edge that ends a cycle with `pm_int`=1, and not before. A shadow write in that same cycle is kept for the next transfer.
- R9: `pwm_out` is 1 exactly when the count is greater than or equal to the active compare value.
- R10: The active period must lie between 1 and 2^W-2. With a period of 1 the counts run 0,1,2,1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| step | input | 1 | Count-rate strobe |
| shadow_wr | input | 1 | Write period_in and compare_in into the shadow registers |
| period_in | input | W | New period value |
| compare_in | input | W | New compare value |
| count | output | W | Counter value |
| count_up | output | 1 | Direction, 1 = counting up |
| pm_ext | output | 1 | External period-match pulse (twice per turnaround) |
| pm_int | output | 1 | Internal period event (up-count only) |
| zero_match | output | 1 | Zero-match pulse |
| pwm_out | output | 1 | PWM output |

## Verification
On every cycle the assertions check the following:
- the counter and direction hold when not stepping;
- the up-count match moves the counter to period+1;
- the bottom turnaround goes to 1 counting up;
- the internal event is a subset of the external pulse and occurs only while counting up;
- every pulse falls on a step;
- each internal event loads the shadow values into the active registers.

Only the bench's scenarios can show the full count trajectory against an independent model. That includes the doubled external pulse around the 0x200 peak, the single internal event per cycle, the delayed effect of a mid-cycle shadow write, the period-1 corner, and the shape of the PWM pulse.

// File: rtl/capwm_timer.sv
module capwm_timer #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_PERIOD  = W'(8),
  parameter logic [W-1:0] RST_COMPARE = W'(4)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         shadow_wr,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] compare_in,
  output logic [W-1:0] count,
  output logic         count_up,
  output logic         pm_ext,
  output logic         pm_int,
  output logic         zero_match,
  output logic         pwm_out
);

  logic [W-1:0] per_sh, cmp_sh, per_act, cmp_act;
  logic adv, at_zero;

  assign adv        = en & step;
  assign at_zero    = (count == '0);
  assign pm_ext     = adv & (count == per_act);
  assign pm_int     = pm_ext & count_up;
  assign zero_match = adv & at_zero;
  assign pwm_out    = (count >= cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      count_up <= 1'b1;
    end else if (adv) begin
      if (count_up) begin
        if (count > per_act) begin
          count    <= count - W'(1);
          count_up <= 1'b0;
        end else begin
          count <= count + W'(1);
        end
      end else if (at_zero) begin
        count    <= W'(1);
        count_up <= 1'b1;
      end else begin
        count <= count - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sh  <= RST_PERIOD;
      cmp_sh  <= RST_COMPARE;
      per_act <= RST_PERIOD;
      cmp_act <= RST_COMPARE;
    end else begin
      if (pm_int) begin
        per_act <= per_sh;
        cmp_act <= cmp_sh;
      end
      if (shadow_wr) begin
        per_sh <= period_in;
        cmp_sh <= compare_in;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && step) |=> $stable(count) && $stable(count_up));

  p_pulse_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_ext || pm_int || zero_match) |-> (en && step));

  p_peak_overshoot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_int |=> (count == $past(count) + W'(1)) && count_up);

  p_bottom_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_match && !count_up |=> (count == W'(1)) && count_up);

  p_int_in_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pm_int |-> pm_ext && count_up);

  p_shadow_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pm_int |=> (per_act == $past(per_sh)) && (cmp_act == $past(cmp_sh)));

endmodule

// File: tb/tb_capwm_timer.sv
module tb_capwm_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, step = 1'b0, shadow_wr = 1'b0;
  logic [W-1:0] period_in = '0, compare_in = '0;
  logic [W-1:0] count;
  logic count_up, pm_ext, pm_int, zero_match, pwm_out;

  always #10 clk = ~clk;

  capwm_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step), .shadow_wr(shadow_wr),
    .period_in(period_in), .compare_in(compare_in), .count(count),
    .count_up(count_up), .pm_ext(pm_ext), .pm_int(pm_int),
    .zero_match(zero_match), .pwm_out(pwm_out)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic up, ext, intv, zm, pwm;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [W-1:0] m_cnt = '0, m_per = W'(8), m_cmp = W'(4), m_psh = W'(8), m_csh = W'(4);
  logic m_up = 1'b1;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic s, input logic w,
                       input logic [W-1:0] p, input logic [W-1:0] c, input string tag);
    exp_t x;
    logic adv, top;
    @(negedge clk);
    en = e; step = s; shadow_wr = w; period_in = p; compare_in = c;
    adv = e && s;
    top = m_cnt > m_per;
    x.cnt = m_cnt; x.up = m_up; x.tag = tag;
    x.ext = adv && (m_cnt == m_per);
    x.intv = x.ext && m_up;
    x.zm = adv && (m_cnt == '0);
    x.pwm = (m_cnt >= m_cmp);
    q.push_back(x);
    if (x.intv) begin m_per = m_psh; m_cmp = m_csh; end
    if (w) begin m_psh = p; m_csh = c; end
    if (adv) begin
      if (m_up) begin
        if (top) begin m_cnt = m_cnt - 1'b1; m_up = 1'b0; end
        else m_cnt = m_cnt + 1'b1;
      end else if (m_cnt == '0) begin
        m_cnt = W'(1); m_up = 1'b1;
      end else m_cnt = m_cnt - 1'b1;
    end
  endtask

  always @(negedge clk) begin
    exp_t x;
    #5;
    if (q.size() > 0) begin
      x = q.pop_front();
      chk(x.tag, "count", count, x.cnt);
      chk(x.tag, "count_up", W'(count_up), W'(x.up));
      chk("R5", "pm_ext", W'(pm_ext), W'(x.ext));
      chk("R6", "pm_int", W'(pm_int), W'(x.intv));
      chk("R7", "zero_match", W'(zero_match), W'(x.zm));
      chk("R9", "pwm_out", W'(pwm_out), W'(x.pwm));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 200000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) drive(1'b0, 1'b0, 1'b0, '0, '0, "R1");
    repeat (45) drive(1'b1, 1'b1, 1'b0, '0, '0, "R3_R4");
    for (int i = 0; i < 30; i++) drive(1'b1, (i % 3) == 0, 1'b0, '0, '0, "R2");
    repeat (5) drive(1'b0, 1'b1, 1'b0, '0, '0, "R2");
    drive(1'b1, 1'b1, 1'b1, W'(5), W'(2), "R8");
    repeat (50) drive(1'b1, 1'b1, 1'b0, '0, '0, "R8");
    drive(1'b1, 1'b1, 1'b1, W'(1), W'(1), "R10");
    repeat (40) drive(1'b1, 1'b1, 1'b0, '0, '0, "R10");
    drive(1'b1, 1'b1, 1'b1, 16'h200, 16'h100, "R3");
    repeat (1300) drive(1'b1, 1'b1, 1'b0, '0, '0, "R3");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule